// File: doc/BRIEF.md
# Paged Memory-Management Register File

This block is the register store behind a paged address-relocation unit. For each of three privilege modes (kernel, supervisor, user) it keeps eight instruction-space pages and eight data-space pages, and each page has a base register and a descriptor register. It also holds three control registers: a status register, an auto-increment log register and an extended-control register. Software reaches every register through a 16-bit register bus with word and byte access. The relocation unit reads page registers through a separate lookup port, sees the status and extended-control words directly, and raises or lowers status bits with set and clear masks.

The block does no translation and raises no traps. The write path applies a per-register rule. Descriptor writes drop their access-flag bits. A write to the status register cannot change its reserved bits, and it cannot overwrite its low byte alone while an error is held. The extended-control register keeps only its defined bits. The log register records register auto-increments as a shifting pair of bytes.

Top module: `mmu_regfile`

## Requirements
- R1: Bus address bit 8 = 0 selects page registers: bit 7 = 1 selects a base register and 0 selects a descriptor. Bits 6:5 give the mode: 0 is kernel, 1 is supervisor, 3 is user. Bit 4 = 1 selects the data set, and bits 3:1 give the page. Mode code 2 reads as zero, and a write to it changes no register.
- R2: A byte write (bus_byte = 1) takes its data from bus_wdata[7:0]. It replaces the high byte when address bit 0 is 1 and the low byte when bit 0 is 0. The other byte keeps its value.
- R3: After any write to a descriptor, bits 7:4 of that descriptor are zero. All other bits take the written value.
- R4: The control registers are at bus address bit 8 = 1 with bits 7:3 = 0. Bits 2:1 select the register: 0 is status, 1 is log, 3 is extended control, and 2 reads zero. A write to status always stores bits 11:10 as zero. If bit 0 of the written value is 1, bits 15:13 are stored as zero.
- R5: If status bits 15:13 are not all zero and the written value has bit 0 = 0, the stored status is the written value with bits 15:8 zeroed.
- R6: A write to extended control stores only the bits of octal mask 067. A bus write to the log register has no effect.
- R7: On a cycle with rec_valid = 1, the log register becomes {old[7:0], rec_delta, rec_regno}. The delta goes in bits 7:3 and the register number in bits 2:0.
- R8: log_clear = 1 zeroes the log register and takes priority over a record in the same cycle.
- R9: After reset all registers read zero.
- R10: Read data is combinational. A byte read returns the addressed byte in bits 7:0 and zero in bits 15:8.
- R11: The lookup port returns the base and descriptor of (lk_mode, lk_dspace, lk_page) in the same cycle. It returns zero for mode code 2.
- R12: When there is no bus write to status, status becomes (old & ~st_clr) | st_set, with bits 11:10 forced to zero. A bus write to status in the same cycle takes priority over set and clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 9 | Register bus address |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_wdata | input | 16 | Write data (byte data in bits 7:0) |
| bus_rdata | output | 16 | Combinational read data |
| rec_valid | input | 1 | Record an auto-increment in the log register |
| rec_delta | input | 5 | Register delta to record |
| rec_regno | input | 3 | Register number to record |
| log_clear | input | 1 | Zero the log register |
| st_set | input | 16 | Status bits to set |
| st_clr | input | 16 | Status bits to clear |
| lk_mode | input | 2 | Lookup mode code |
| lk_dspace | input | 1 | Lookup data-set select |
| lk_page | input | 3 | Lookup page index |
| lk_base | output | 16 | Base register of the looked-up page |
| lk_desc | output | 16 | Descriptor of the looked-up page |
| stat_o | output | 16 | Status register |
| ext_o | output | 16 | Extended-control register |

## Verification
The directed phase writes distinct values to pages that differ in only one address field (mode, data-set bit, page index). A decode slip therefore shows up as a neighbour being overwritten, or as mode code 2 taking a value. Byte writes to both lanes of base, descriptor, status and extended-control registers separate the lane merge from the per-register masks. Status writes with the error bits first clear and then held, with bit 0 low and high, and with set and clear masks in the same cycle, separate the held-error rule from the reserved-bit rule and from the priority rule. A long random mix of bus traffic, records, clears, status masks and lookups is then compared every clock against a behavioural model.

// File: rtl/mmu_rf_pkg.sv
package mmu_rf_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int PAGE_W = 3;
    localparam int NPAGE  = 1 << PAGE_W;
    localparam int NSPACE = 2;
    localparam int ADDR_W = 9;
    localparam int NBANK  = 3;
    localparam int DELTA_W = 5;
    localparam int REGNO_W = 3;

    localparam logic [DATA_W-1:0] DESC_KEEP = 16'hFF0F;
    localparam logic [DATA_W-1:0] EXT_KEEP  = 16'o067;
    localparam logic [DATA_W-1:0] STAT_RSVD = 16'h0C00;
    localparam logic [DATA_W-1:0] STAT_ERR  = 16'hE000;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_LOG  = 2'd1,
        SEL_NONE = 2'd2,
        SEL_EXT  = 2'd3
    } ctl_sel_e;

    // Combine bus data with the current register value for word or byte lanes
    function automatic logic [DATA_W-1:0] merge_word(
        input logic [DATA_W-1:0] old,
        input logic [DATA_W-1:0] wd,
        input logic              byte_w,
        input logic              hi
    );
        logic [DATA_W-1:0] r;
        if (!byte_w)
            r = wd;
        else if (hi)
            r = {wd[BYTE_W-1:0], old[BYTE_W-1:0]};
        else
            r = {old[DATA_W-1:BYTE_W], wd[BYTE_W-1:0]};
        return r;
    endfunction
endpackage

// File: rtl/mmu_bank.sv
module mmu_bank
    import mmu_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel_base,
    input  logic              dsp,
    input  logic [PAGE_W-1:0] pg,
    input  logic              byte_w,
    input  logic              hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_o,
    input  logic              lk_dsp,
    input  logic [PAGE_W-1:0] lk_pg,
    output logic [DATA_W-1:0] lk_base_o,
    output logic [DATA_W-1:0] lk_desc_o
);
    typedef struct packed {
        logic [NSPACE-1:0][NPAGE-1:0][DATA_W-1:0] base;
        logic [NSPACE-1:0][NPAGE-1:0][DATA_W-1:0] desc;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            if (sel_base)
                bank_d.base[dsp][pg] = merge_word(bank_q.base[dsp][pg], wdata, byte_w, hi);
            else
                bank_d.desc[dsp][pg] = merge_word(bank_q.desc[dsp][pg], wdata, byte_w, hi) & DESC_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign rd_o      = sel_base ? bank_q.base[dsp][pg] : bank_q.desc[dsp][pg];
    assign lk_base_o = bank_q.base[lk_dsp][lk_pg];
    assign lk_desc_o = bank_q.desc[lk_dsp][lk_pg];

    AST_DESC_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel_base) |=> (bank_q.desc[$past(dsp)][$past(pg)][7:4] == 4'h0)) // R3
        else $error("descriptor flag bits survived a write");

    AST_BASE_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel_base && !byte_w) |=> (bank_q.base[$past(dsp)][$past(pg)] == $past(wdata))) // R1
        else $error("base word write not stored");
endmodule

// File: rtl/mmu_ctl.sv
module mmu_ctl
    import mmu_rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         sel,
    input  logic               byte_w,
    input  logic               hi,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rec_valid,
    input  logic [DELTA_W-1:0] rec_delta,
    input  logic [REGNO_W-1:0] rec_regno,
    input  logic               log_clear,
    input  logic [DATA_W-1:0]  st_set,
    input  logic [DATA_W-1:0]  st_clr,
    output logic [DATA_W-1:0]  stat_o,
    output logic [DATA_W-1:0]  ilog_o,
    output logic [DATA_W-1:0]  ext_o
);
    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] ilog;
        logic [DATA_W-1:0] ext;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    ctl_sel_e which;
    logic [DATA_W-1:0] stat_new;

    assign which = ctl_sel_e'(sel);

    always_comb begin
        ctl_d    = ctl_q;
        stat_new = merge_word(ctl_q.stat, wdata, byte_w, hi) & ~STAT_RSVD;
        if (stat_new[0])
            stat_new = stat_new & ~STAT_ERR;
        if (((ctl_q.stat & STAT_ERR) != '0) && !stat_new[0])
            stat_new = {{(DATA_W-BYTE_W){1'b0}}, stat_new[BYTE_W-1:0]};

        if (we && which == SEL_STAT)
            ctl_d.stat = stat_new;
        else
            ctl_d.stat = ((ctl_q.stat & ~st_clr) | st_set) & ~STAT_RSVD;

        if (we && which == SEL_EXT)
            ctl_d.ext = merge_word(ctl_q.ext, wdata, byte_w, hi) & EXT_KEEP;

        if (log_clear)
            ctl_d.ilog = '0;
        else if (rec_valid)
            ctl_d.ilog = {ctl_q.ilog[BYTE_W-1:0], rec_delta, rec_regno};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    assign stat_o = ctl_q.stat;
    assign ilog_o = ctl_q.ilog;
    assign ext_o  = ctl_q.ext;

    AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[11:10] == 2'b00) // R4
        else $error("status reserved bits set");

    AST_STAT_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && which == SEL_STAT && !byte_w && wdata[0]) |=> (stat_o[15:13] == 3'b000)) // R4
        else $error("error bits kept after enable write");

    AST_STAT_HELD_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && which == SEL_STAT && !byte_w && !wdata[0] && (stat_o[15:13] != 3'b000))
        |=> (stat_o[15:8] == 8'h00)) // R5
        else $error("high status byte written while error held");

    AST_EXT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_o & ~EXT_KEEP) == '0) // R6
        else $error("extended control holds undefined bits");

    AST_LOG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !log_clear) |=> ((ilog_o[15:8] == $past(ilog_o[7:0]))
                                       && (ilog_o[7:3] == $past(rec_delta))
                                       && (ilog_o[2:0] == $past(rec_regno)))) // R7
        else $error("log record mispacked");

    AST_LOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        log_clear |=> (ilog_o == '0)) // R8
        else $error("log not cleared");
endmodule

// File: rtl/mmu_regfile.sv
module mmu_regfile
    import mmu_rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_byte,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               rec_valid,
    input  logic [DELTA_W-1:0] rec_delta,
    input  logic [REGNO_W-1:0] rec_regno,
    input  logic               log_clear,
    input  logic [DATA_W-1:0]  st_set,
    input  logic [DATA_W-1:0]  st_clr,
    input  logic [1:0]         lk_mode,
    input  logic               lk_dspace,
    input  logic [PAGE_W-1:0]  lk_page,
    output logic [DATA_W-1:0]  lk_base,
    output logic [DATA_W-1:0]  lk_desc,
    output logic [DATA_W-1:0]  stat_o,
    output logic [DATA_W-1:0]  ext_o
);
    logic              hi_lane, sel_base, dsp, in_bank, in_ctl;
    logic [1:0]        bmode;
    logic [PAGE_W-1:0] pg;
    logic [DATA_W-1:0] ilog, word_rd, ctl_rd;
    logic [DATA_W-1:0] bank_rd  [NBANK];
    logic [DATA_W-1:0] bank_lkb [NBANK];
    logic [DATA_W-1:0] bank_lkd [NBANK];

    assign hi_lane  = bus_addr[0];
    assign pg       = bus_addr[PAGE_W:1];
    assign dsp      = bus_addr[4];
    assign bmode    = bus_addr[6:5];
    assign sel_base = bus_addr[7];
    assign in_bank  = !bus_addr[8];
    assign in_ctl   = bus_addr[8] && (bus_addr[7:3] == 5'd0);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            localparam logic [1:0] CODE = (b == NBANK-1) ? 2'd3 : 2'(b);
            mmu_bank i_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .we        (bus_we && in_bank && (bmode == CODE)),
                .sel_base  (sel_base),
                .dsp       (dsp),
                .pg        (pg),
                .byte_w    (bus_byte),
                .hi        (hi_lane),
                .wdata     (bus_wdata),
                .rd_o      (bank_rd[b]),
                .lk_dsp    (lk_dspace),
                .lk_pg     (lk_page),
                .lk_base_o (bank_lkb[b]),
                .lk_desc_o (bank_lkd[b])
            );
        end
    endgenerate

    mmu_ctl i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we && in_ctl),
        .sel       (bus_addr[2:1]),
        .byte_w    (bus_byte),
        .hi        (hi_lane),
        .wdata     (bus_wdata),
        .rec_valid (rec_valid),
        .rec_delta (rec_delta),
        .rec_regno (rec_regno),
        .log_clear (log_clear),
        .st_set    (st_set),
        .st_clr    (st_clr),
        .stat_o    (stat_o),
        .ilog_o    (ilog),
        .ext_o     (ext_o)
    );

    always_comb begin
        case (ctl_sel_e'(bus_addr[2:1]))
            SEL_STAT: ctl_rd = stat_o;
            SEL_LOG:  ctl_rd = ilog;
            SEL_EXT:  ctl_rd = ext_o;
            default:  ctl_rd = '0;
        endcase
    end

    always_comb begin
        word_rd = '0;
        lk_base = '0;
        lk_desc = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (in_bank && bmode == ((b == NBANK-1) ? 2'd3 : 2'(b)))
                word_rd = bank_rd[b];
            if (lk_mode == ((b == NBANK-1) ? 2'd3 : 2'(b))) begin
                lk_base = bank_lkb[b];
                lk_desc = bank_lkd[b];
            end
        end
        if (in_ctl)
            word_rd = ctl_rd;
    end

    assign bus_rdata = !bus_byte ? word_rd
                     : {{(DATA_W-BYTE_W){1'b0}},
                        hi_lane ? word_rd[DATA_W-1:BYTE_W] : word_rd[BYTE_W-1:0]};

    AST_BYTE_READ_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_byte |-> (bus_rdata[15:8] == 8'h00)) // R10
        else $error("byte read leaked high bits");

    AST_HOLE_LOOKUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_mode == 2'd2) |-> ((lk_base == '0) && (lk_desc == '0))) // R11
        else $error("unused mode returned data");
endmodule

// File: tb/test_mmu_regfile.sv
module test_mmu_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_byte = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rec_valid = 1'b0;
    logic [4:0]  rec_delta = '0;
    logic [2:0]  rec_regno = '0;
    logic        log_clear = 1'b0;
    logic [15:0] st_set = '0;
    logic [15:0] st_clr = '0;
    logic [1:0]  lk_mode = '0;
    logic        lk_dspace = 1'b0;
    logic [2:0]  lk_page = '0;
    logic [15:0] lk_base, lk_desc, stat_o, ext_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_base [4][2][8];
    logic [15:0] m_desc [4][2][8];
    logic [15:0] m_stat, m_log, m_ext;

    always #5 clk = ~clk;

    mmu_regfile i_mmu_regfile (.*);

    function automatic logic [8:0] pa(input bit isbase, input int mode, input bit d,
                                      input int page, input bit hi);
        return {1'b0, isbase, 2'(mode), d, 3'(page), hi};
    endfunction

    function automatic logic [8:0] ca(input int sel, input bit hi);
        return {1'b1, 5'd0, 2'(sel), hi};
    endfunction

    function automatic logic [15:0] lane(input logic [15:0] old, input logic [15:0] d,
                                         input bit b, input bit hi);
        if (!b) return d;
        if (hi) return (old & 16'h00FF) | ({8'h00, d[7:0]} << 8);
        return (old & 16'hFF00) | {8'h00, d[7:0]};
    endfunction

    function automatic logic [15:0] m_read(input logic [8:0] a, input bit b);
        logic [15:0] w;
        w = 16'h0;
        if (a[8]) begin
            if (a[7:3] == 5'd0) begin
                if (a[2:1] == 2'd0) w = m_stat;
                else if (a[2:1] == 2'd1) w = m_log;
                else if (a[2:1] == 2'd3) w = m_ext;
            end
        end else if (a[6:5] != 2'd2) begin
            w = a[7] ? m_base[a[6:5]][a[4]][a[3:1]] : m_desc[a[6:5]][a[4]][a[3:1]];
        end
        if (b) w = a[0] ? (w >> 8) : (w & 16'h00FF);
        return w;
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic [15:0] v;
        bit stat_wr;
        stat_wr = 1'b0;
        if (bus_we) begin
            if (bus_addr[8]) begin
                if (bus_addr[7:3] == 5'd0 && bus_addr[2:1] == 2'd0) begin
                    stat_wr = 1'b1;
                    v = lane(m_stat, bus_wdata, bus_byte, bus_addr[0]);
                    v[11] = 1'b0; v[10] = 1'b0;
                    if (v[0]) v[15:13] = 3'b000;
                    if (m_stat[15:13] != 3'b000 && !v[0]) v = v & 16'h00FF;
                    m_stat = v;
                end else if (bus_addr[7:3] == 5'd0 && bus_addr[2:1] == 2'd3) begin
                    m_ext = lane(m_ext, bus_wdata, bus_byte, bus_addr[0]) & 16'h0037;
                end
            end else if (bus_addr[6:5] != 2'd2) begin
                if (bus_addr[7])
                    m_base[bus_addr[6:5]][bus_addr[4]][bus_addr[3:1]] =
                        lane(m_base[bus_addr[6:5]][bus_addr[4]][bus_addr[3:1]], bus_wdata, bus_byte, bus_addr[0]);
                else
                    m_desc[bus_addr[6:5]][bus_addr[4]][bus_addr[3:1]] =
                        lane(m_desc[bus_addr[6:5]][bus_addr[4]][bus_addr[3:1]], bus_wdata, bus_byte, bus_addr[0])
                        & ~16'h00F0;
            end
        end
        if (!stat_wr) begin
            m_stat = (m_stat & ~st_clr) | st_set;
            m_stat[11:10] = 2'b00;
        end
        if (log_clear) m_log = 16'h0;
        else if (rec_valid) m_log = (m_log << 8) | 16'(rec_delta) * 16'd8 | 16'(rec_regno);
    endtask

    task automatic compare_outputs();
        chk(stat_o, m_stat, "R12 status");
        chk(ext_o, m_ext, "R6 extended");
        chk(lk_base, (lk_mode == 2'd2) ? 16'h0 : m_base[lk_mode][lk_dspace][lk_page], "R11 lookup base");
        chk(lk_desc, (lk_mode == 2'd2) ? 16'h0 : m_desc[lk_mode][lk_dspace][lk_page], "R11 lookup desc");
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_outputs();
        bus_we = 1'b0; rec_valid = 1'b0; log_clear = 1'b0;
        st_set = '0; st_clr = '0;
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d, input bit b);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = b;
        tick();
    endtask

    task automatic rd(input logic [8:0] a, input bit b, input logic [15:0] exp, input string tag);
        bus_addr = a; bus_byte = b;
        #1;
        chk(bus_rdata, exp, tag);
        chk(bus_rdata, m_read(a, b), {tag, " model"});
    endtask

    task automatic rec(input logic [4:0] d, input logic [2:0] r, input bit clr);
        rec_valid = 1'b1; rec_delta = d; rec_regno = r; log_clear = clr;
        tick();
    endtask

    initial begin
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 8; p++) begin
                    m_base[m][s][p] = '0;
                    m_desc[m][s][p] = '0;
                end
        m_stat = '0; m_log = '0; m_ext = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        compare_outputs();
        rd(ca(0, 0), 0, 16'h0, "R9 status reset");
        rd(ca(1, 0), 0, 16'h0, "R9 log reset");
        rd(ca(3, 0), 0, 16'h0, "R9 ext reset");
        rd(pa(1, 3, 1, 7, 0), 0, 16'h0, "R9 user base reset");

        // R1: decode of mode, set and page
        wr(pa(1, 0, 0, 3, 0), 16'h1234, 0);
        wr(pa(1, 3, 1, 5, 0), 16'hABCD, 0);
        wr(pa(1, 1, 0, 7, 0), 16'h5A5A, 0);
        rd(pa(1, 0, 0, 3, 0), 0, 16'h1234, "R1 kernel I base");
        rd(pa(1, 0, 1, 3, 0), 0, 16'h0000, "R1 kernel D base untouched");
        rd(pa(1, 3, 1, 5, 0), 0, 16'hABCD, "R1 user D base");
        rd(pa(1, 3, 1, 4, 0), 0, 16'h0000, "R1 neighbour page untouched");
        rd(pa(1, 1, 0, 7, 0), 0, 16'h5A5A, "R1 supervisor base");
        rd(pa(0, 1, 0, 7, 0), 0, 16'h0000, "R1 descriptor distinct from base");
        wr(pa(1, 2, 0, 3, 0), 16'hFFFF, 0);
        rd(pa(1, 2, 0, 3, 0), 0, 16'h0000, "R1 mode 2 reads zero");
        rd(pa(1, 0, 0, 3, 0), 0, 16'h1234, "R1 mode 2 write ignored");
        rd(pa(1, 3, 0, 3, 0), 0, 16'h0000, "R1 mode 2 write ignored user");

        // R2 / R10: byte lanes
        wr(pa(1, 0, 0, 3, 0), 16'h0056, 1);
        rd(pa(1, 0, 0, 3, 0), 0, 16'h1256, "R2 low byte write");
        wr(pa(1, 0, 0, 3, 1), 16'h009A, 1);
        rd(pa(1, 0, 0, 3, 0), 0, 16'h9A56, "R2 high byte write");
        rd(pa(1, 0, 0, 3, 1), 1, 16'h009A, "R10 byte read high lane");
        rd(pa(1, 0, 0, 3, 0), 1, 16'h0056, "R10 byte read low lane");

        // R3: descriptor flag bits
        wr(pa(0, 3, 0, 2, 0), 16'hFFFF, 0);
        rd(pa(0, 3, 0, 2, 0), 0, 16'hFF0F, "R3 word write clears 7:4");
        wr(pa(0, 3, 0, 2, 0), 16'h00F3, 1);
        rd(pa(0, 3, 0, 2, 0), 0, 16'hFF03, "R3 byte write clears 7:4");
        wr(pa(0, 3, 0, 2, 1), 16'h0012, 1);
        rd(pa(0, 3, 0, 2, 0), 0, 16'h1203, "R3 high byte write");

        // R4 / R5: status write rules
        wr(ca(0, 0), 16'hFFFE, 0);
        rd(ca(0, 0), 0, 16'hF3FE, "R4 reserved bits zero");
        wr(ca(0, 0), 16'h1234, 0);
        rd(ca(0, 0), 0, 16'h0034, "R5 held error keeps low byte only");
        wr(ca(0, 0), 16'hE000, 0);
        rd(ca(0, 0), 0, 16'hE000, "R5 not held writes freely");
        wr(ca(0, 0), 16'hEC01, 0);
        rd(ca(0, 0), 0, 16'h0001, "R4 bit0 clears error bits");

        // R12: set / clear masks and priority
        st_set = 16'h8000; tick();
        rd(ca(0, 0), 0, 16'h8001, "R12 set mask");
        st_clr = 16'h0001; st_set = 16'h0C00; tick();
        rd(ca(0, 0), 0, 16'h8000, "R12 clear mask and reserved");
        st_set = 16'h4000;
        wr(ca(0, 0), 16'h0005, 0);
        rd(ca(0, 0), 0, 16'h0005, "R12 bus write wins over set");

        // R6: extended control and log write
        wr(ca(3, 0), 16'hFFFF, 0);
        rd(ca(3, 0), 0, 16'h0037, "R6 ext mask");
        wr(ca(3, 1), 16'h0000, 1);
        rd(ca(3, 0), 0, 16'h0037, "R6 ext high byte masked");
        wr(ca(1, 0), 16'hBEEF, 0);
        rd(ca(1, 0), 0, 16'h0000, "R6 log bus write ignored");
        wr(ca(2, 0), 16'hBEEF, 0);
        rd(ca(2, 0), 0, 16'h0000, "R4 hole reads zero");

        // R7 / R8: log records
        rec(5'h1F, 3'd5, 0);
        rd(ca(1, 0), 0, 16'h00FD, "R7 first record");
        rec(5'h02, 3'd7, 0);
        rd(ca(1, 0), 0, 16'hFD17, "R7 second record shifts");
        rd(ca(1, 1), 1, 16'h00FD, "R10 log byte read");
        rec(5'h10, 3'd1, 1);
        rd(ca(1, 0), 0, 16'h0000, "R8 clear wins over record");

        // R11: lookup port
        lk_mode = 2'd0; lk_dspace = 1'b0; lk_page = 3'd3; tick();
        chk(lk_base, 16'h9A56, "R11 kernel lookup");
        lk_mode = 2'd3; lk_dspace = 1'b0; lk_page = 3'd2; tick();
        chk(lk_desc, 16'h1203, "R11 user descriptor lookup");
        lk_mode = 2'd2; tick();
        chk(lk_base, 16'h0000, "R11 mode 2 lookup");

        // random mix compared every clock
        for (int i = 0; i < 1500; i++) begin
            bus_we    = ($urandom_range(0, 1) == 1);
            bus_addr  = 9'($urandom);
            if ($urandom_range(0, 3) == 0) bus_addr[7:3] = 5'd0;
            bus_byte  = ($urandom_range(0, 2) == 0);
            bus_wdata = 16'($urandom);
            if (bus_byte) bus_wdata[15:8] = 8'h00;
            rec_valid = ($urandom_range(0, 3) == 0);
            rec_delta = 5'($urandom);
            rec_regno = 3'($urandom);
            log_clear = ($urandom_range(0, 15) == 0);
            st_set    = ($urandom_range(0, 7) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0;
            st_clr    = ($urandom_range(0, 7) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0;
            lk_mode   = 2'($urandom);
            lk_dspace = 1'($urandom);
            lk_page   = 3'($urandom);
            tick();
            bus_addr = 9'($urandom);
            if ($urandom_range(0, 3) == 0) bus_addr[7:3] = 5'd0;
            bus_byte = ($urandom_range(0, 2) == 0);
            #1;
            chk(bus_rdata, m_read(bus_addr, bus_byte), "R1 R10 random read");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule